// File: doc/BRIEF.md
# Recovered Clock Range Monitor

This block decides whether a clock recovered from a serial data stream runs close enough to the local reference frequency. It lives on a single system clock and sees both clocks only as single-cycle strobes: one strobe per recovered character clock and one per reference character clock. A measurement window spans a fixed number of recovered strobes. During the window the block counts reference strobes and, when the window closes, compares the count against a tolerance band derived from a parts-per-million limit.

A count outside the band raises a request that makes the clock-recovery loop follow the reference, and drives the active-low link-fault output LOW. The request stays up for at least one whole further window. Counting goes on during the forced window, and the request is dropped, with the fault cleared, only when a window ends with a count inside the band. A disabled channel reports a fault continuously. When the channel is enabled again, a fresh window starts.

With the default parameters, a window spans 4096 recovered strobes and the limit is 1500 ppm, which gives an accepted band of 4090 to 4102 reference strobes.

Top module: `rclk_range_monitor`

## Requirements
- R1: While reset is asserted and directly after it, `force_ref` is 1 and `lfi_n` is 0, and both strobe counters start from zero.
- R2: A window closes on the WINDOW_TICKS-th `rec_tick` counted since the previous window closed, or since the channel was enabled. The outputs change only on the clock edge at which a window closes, or because `chan_en` is low.
- R3: Let TOL = floor(WINDOW_TICKS * PPM_LIMIT / 1000000). A window is in range when its `ref_tick` count C satisfies WINDOW_TICKS - TOL <= C <= WINDOW_TICKS + TOL. With the defaults, that is 4090 <= C <= 4102. A `ref_tick` that arrives in the same cycle as the closing `rec_tick` counts toward the closing window.
- R4: A window that is not in range sets `force_ref` to 1 and `lfi_n` to 0 from the next clock edge. Both hold at least until the end of the next window.
- R5: `force_ref` falls to 0 and `lfi_n` rises to 1 only at the close of an in-range window while the channel is enabled. `lfi_n` is never 1 while `force_ref` is 1.
- R6: While `chan_en` is 0, from the next edge on `force_ref` is 1 and `lfi_n` is 0, whatever strobes arrive, and both counters are held at zero.
- R7: After `chan_en` returns to 1, a fresh window begins on the first enabled cycle. The fault persists until that window closes in range.
- R8: The reference counter saturates instead of wrapping. A window with more reference strobes than the counter can hold is judged out of range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_en | input | 1 | Channel enable; 0 holds a permanent fault |
| rec_tick | input | 1 | One-cycle strobe per recovered character clock |
| ref_tick | input | 1 | One-cycle strobe per reference character clock |
| force_ref | output | 1 | Request for the recovery loop to track the reference |
| lfi_n | output | 1 | Link-fault indicator, LOW on fault |

## Verification
The assertions assume that both strobes and `chan_en` are synchronous to `clk` and that each strobe lasts at most one cycle per event. They also assume that reset lasts at least one edge, so the counters start from a known value. The stimulus changes every input on the falling clock edge. It derives each window from an exact count of cycles, placing a recovered strobe on the last cycle of every strobe period and spreading a chosen number of reference strobes evenly across the same cycles. Every window boundary therefore falls on a known cycle, and each band edge can be hit exactly.

// File: rtl/rcm_pkg.sv
package rcm_pkg;

  // Half-width of the accepted band in reference ticks, rounded down.
  function automatic int tol_ticks(input int window, input int ppm);
    longint prod;
    prod = longint'(window) * longint'(ppm);
    return int'(prod / 64'd1000000);
  endfunction

  // One counting step that sticks at the ceiling instead of wrapping.
  function automatic int unsigned sat_step(input int unsigned cnt,
                                           input logic inc,
                                           input int unsigned cap);
    if (!inc || cnt >= cap) return cnt;
    return cnt + 1;
  endfunction

  // Band test, kept here so the band arithmetic lives in one place.
  function automatic logic in_band(input int unsigned cnt,
                                   input int lo, input int hi);
    return (int'(cnt) >= lo) && (int'(cnt) <= hi);
  endfunction

endpackage

// File: rtl/rcm_window_counter.sv
module rcm_window_counter #(
  parameter int WINDOW_TICKS = 4096,
  parameter int WIN_W        = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic tick_i,
  output logic done_o
);

  logic [WIN_W-1:0] cnt_q;
  logic             at_last;

  assign at_last = (cnt_q == WIN_W'(WINDOW_TICKS - 1));
  assign done_o  = tick_i && at_last && !clr_i;

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= at_last ? '0 : cnt_q + 1'b1;
    end
  end

  // R2: a closed window restarts counting from zero
  a_r2_restart_after_close: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (cnt_q == '0));

  // R6: a disabled channel keeps the window count at zero
  a_r6_window_held: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/rcm_ref_counter.sv
module rcm_ref_counter #(
  parameter int REF_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             close_i,
  input  logic             tick_i,
  output logic [REF_W-1:0] total_o
);

  localparam int unsigned CAP = (1 << REF_W) - 1;

  logic [REF_W-1:0] cnt_q;

  // The total includes a tick that coincides with the closing cycle.
  assign total_o = REF_W'(rcm_pkg::sat_step(int'(cnt_q), tick_i, CAP));

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i || close_i) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= total_o;
    end
  end

  // R8: within a window the count never falls (no wrap)
  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !close_i) |=> (cnt_q >= $past(cnt_q)));

  // R1/R6: clearing leaves zero behind
  a_r6_ref_held: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i || close_i) |=> (cnt_q == '0));

endmodule

// File: rtl/rcm_range_judge.sv
module rcm_range_judge #(
  parameter int REF_W = 14,
  parameter int LO    = 4090,
  parameter int HI    = 4102
) (
  input  logic [REF_W-1:0] total_i,
  output logic             in_range_o
);

  generate
    if (LO == HI) begin : g_exact
      assign in_range_o = (int'(total_i) == LO);
    end else begin : g_band
      assign in_range_o = rcm_pkg::in_band(int'(total_i), LO, HI);
    end
  endgenerate

endmodule

// File: rtl/rcm_lock_ctrl.sv
module rcm_lock_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic done_i,
  input  logic in_range_i,
  output logic force_o,
  output logic lfi_n_o
);

  always_ff @(posedge clk) begin
    if (!rst_n || !en_i) begin
      force_o <= 1'b1;
      lfi_n_o <= 1'b0;
    end else if (done_i) begin
      force_o <= !in_range_i;
      lfi_n_o <= in_range_i;
    end
  end

  // R4: an out-of-range close forces tracking and flags a fault
  a_r4_fault_on_bad: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && done_i && !in_range_i) |=> (force_o && !lfi_n_o));

  // R5: release only at an enabled in-range close
  a_r5_release_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(force_o) |-> $past(en_i && done_i && in_range_i));

  // R5: no clear link while tracking the reference
  a_r5_no_link_while_forced: assert property (@(posedge clk) disable iff (!rst_n)
    lfi_n_o |-> !force_o);

  // R2: outputs hold between window closes
  a_r2_hold_mid_window: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !done_i) |=> ($stable(force_o) && $stable(lfi_n_o)));

  // R6: disabled channel shows a fault
  a_r6_disabled_fault: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (force_o && !lfi_n_o));

endmodule

// File: rtl/rclk_range_monitor.sv
module rclk_range_monitor #(
  parameter int WINDOW_TICKS = 4096,
  parameter int PPM_LIMIT    = 1500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chan_en,
  input  logic rec_tick,
  input  logic ref_tick,
  output logic force_ref,
  output logic lfi_n
);

  localparam int WIN_W     = (WINDOW_TICKS > 1) ? $clog2(WINDOW_TICKS) : 1;
  localparam int REF_W     = WIN_W + 2;
  localparam int TOL_TICKS = rcm_pkg::tol_ticks(WINDOW_TICKS, PPM_LIMIT);
  localparam int BAND_LO   = WINDOW_TICKS - TOL_TICKS;
  localparam int BAND_HI   = WINDOW_TICKS + TOL_TICKS;

  // Internal events brought out as named wires.
  logic             chan_off;
  logic             win_close;
  logic             win_in_range;
  logic [REF_W-1:0] ref_total;

  assign chan_off = !chan_en;

  rcm_window_counter #(
    .WINDOW_TICKS (WINDOW_TICKS),
    .WIN_W        (WIN_W)
  ) u_window (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (chan_off),
    .tick_i (rec_tick),
    .done_o (win_close)
  );

  rcm_ref_counter #(
    .REF_W (REF_W)
  ) u_refcnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (chan_off),
    .close_i (win_close),
    .tick_i  (ref_tick),
    .total_o (ref_total)
  );

  rcm_range_judge #(
    .REF_W (REF_W),
    .LO    (BAND_LO),
    .HI    (BAND_HI)
  ) u_judge (
    .total_i    (ref_total),
    .in_range_o (win_in_range)
  );

  rcm_lock_ctrl u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (chan_en),
    .done_i     (win_close),
    .in_range_i (win_in_range),
    .force_o    (force_ref),
    .lfi_n_o    (lfi_n)
  );

  // R3: a close with a count inside the band never leaves a fault behind
  a_r3_band_accepts: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && win_close && int'(ref_total) >= BAND_LO && int'(ref_total) <= BAND_HI)
      |=> (lfi_n && !force_ref));

  // R8: a saturated count is never judged in range
  a_r8_saturated_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && win_close && (ref_total == '1)) |=> (force_ref && !lfi_n));

endmodule

// File: tb/test_rclk_range_monitor.sv
`timescale 1ns/1ps
module test_rclk_range_monitor;

  localparam int W   = 512;
  localparam int PPM = 12000;
  // Band from R3, worked out independently: 512*12000 = 6144000 -> 6 ticks.
  localparam int TOL = (W * PPM) / 1000000;
  localparam int LO  = W - TOL;
  localparam int HI  = W + TOL;

  localparam int VEC_N = 9;
  localparam int VEC_REF  [VEC_N] = '{512, 518, 519, 512, 506, 505,   0, 2560, 510};
  localparam int VEC_PER  [VEC_N] = '{  2,   2,   2,   2,   2,   2,   2,    8,   2};
  localparam bit VEC_LOCK [VEC_N] = '{  1,   1,   0,   1,   1,   0,   0,    0,   1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chan_en = 1'b1;
  logic rec_tick = 1'b0;
  logic ref_tick = 1'b0;
  logic force_ref, lfi_n;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  rclk_range_monitor #(.WINDOW_TICKS(W), .PPM_LIMIT(PPM)) i_rclk_range_monitor (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en),
    .rec_tick(rec_tick), .ref_tick(ref_tick),
    .force_ref(force_ref), .lfi_n(lfi_n)
  );

  task automatic check(input string tag, input bit exp_lock);
    checks++;
    if (force_ref !== !exp_lock || lfi_n !== exp_lock) begin
      errors++;
      $display("FAIL %s force_ref=%0b lfi_n=%0b expected force_ref=%0b lfi_n=%0b",
               tag, force_ref, lfi_n, !exp_lock, exp_lock);
    end
  endtask

  // Drives a run of cycles: rec strobe every per cycles, nref ref strobes spread evenly.
  task automatic drive_span(input int ncyc, input int per, input int nref,
                            input bit mid_chk, input bit prev_lock);
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      if (mid_chk && c == ncyc - 1) check("R2 no change before close", prev_lock);
      rec_tick = ((c % per) == per - 1);
      ref_tick = (((c + 1) * nref) / ncyc) != ((c * nref) / ncyc);
    end
    @(negedge clk);
    rec_tick = 1'b0;
    ref_tick = 1'b0;
  endtask

  task automatic run_window(input int nref, input int per, input bit prev_lock);
    drive_span(W * per, per, nref, 1'b1, prev_lock);
  endtask

  initial begin
    bit lock_now;
    string tag;
    repeat (3) @(negedge clk);
    check("R1 during reset", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", 1'b0);

    // Vector walk: R3 band edges, R4 force/release, R8 saturation.
    lock_now = 1'b0;
    for (int i = 0; i < VEC_N; i++) begin
      run_window(VEC_REF[i], VEC_PER[i], lock_now);
      if (VEC_PER[i] != 2)   tag = "R8 oversized count rejected";
      else if (VEC_LOCK[i])  tag = "R3 in band locks (R5 release)";
      else                   tag = "R4 out of band forces";
      check(tag, VEC_LOCK[i]);
      if (VEC_LOCK[i] != ((VEC_REF[i] >= LO) && (VEC_REF[i] <= HI)))
        $display("vector %0d table disagrees with band", i);
      lock_now = VEC_LOCK[i];
    end

    // R4: one in-range window after a fault is needed; a bad one then a good one.
    run_window(600, 2, 1'b1);
    check("R4 fault after lock", 1'b0);
    run_window(W, 2, 1'b0);
    check("R4 release after in-range window", 1'b1);

    // R6: disable while locked, strobes keep arriving in range.
    chan_en = 1'b0;
    @(negedge clk);
    check("R6 fault on disable", 1'b0);
    drive_span(W * 2, 2, W, 1'b0, 1'b0);
    check("R6 fault held while disabled", 1'b0);

    // R7: re-enable after a partial window; fresh window must span W strobes.
    chan_en = 1'b1;
    drive_span(W, 2, W / 2, 1'b0, 1'b0);
    check("R7 still faulted mid window", 1'b0);
    chan_en = 1'b0;
    repeat (4) @(negedge clk);
    chan_en = 1'b1;
    run_window(W, 2, 1'b0);
    check("R7 lock after fresh window", 1'b1);

    // R1: reset while locked returns to fault.
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1 reset while locked", 1'b0);
    rst_n = 1'b1;
    run_window(HI, 2, 1'b0);
    check("R3 upper edge after reset", 1'b1);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule